// File: doc/BRIEF.md
# Iterative DES Block Cipher Engine

This block encrypts or decrypts one 64-bit block under a 64-bit key, using one Feistel round per clock. A single round datapath is reused for every round, and a key schedule computes each 48-bit subkey as the round needs it. A one-cycle `start` strobe latches the input block, the key and the direction. Sixteen cycles later the 64-bit result sits in an output register and `done` pulses.

Decryption uses the same round sequence as encryption. The only difference is that the key halves rotate the other way, so the subkeys arrive last to first. The block is meant to sit inside a larger cipher subsystem that builds chaining or multi-key schemes on top of it. Those schemes are not part of this block.

Bit convention: bit 63 of every 64-bit port is the first bit of the cipher's numbering, and bit 0 is the last. Key bits 0, 8, 16, … 56 (the least significant bit of each byte) are parity positions.

Top module: `des_iter_core`

## Requirements
- R1: With `mode_dec`=0, key 133457799BBCDFF1 and block 0123456789ABCDEF give result 85E813540F0AB405. An all-zero key and block give 8CA64DE9C1B123A7, and an all-ones key and block give 7359B2163E4EDC58.
- R2: With `mode_dec`=1, each result of R1 under the same key decrypts back to the original block.
- R3: `done` rises exactly 16 rising edges after the edge that accepted `start`.
- R4: `done` is high for exactly one cycle per accepted operation.
- R5: A `start` pulse while an operation is in progress is ignored. Neither that operation's result nor its timing changes.
- R6: `blk_out` changes only on the edge that raises `done`, and then holds until the next result.
- R7: The eight parity key bits (bit 8·b for b = 0..7) have no effect on the result.
- R8: For any key and block, decrypting the encryption result returns the original block.
- R9: Encrypting the bitwise complement of a block under the complemented key gives the complement of the original result.
- R10: For each of the keys 0101010101010101, FEFEFEFEFEFEFEFE, E0E0E0E0F1F1F1F1 and 1F1F1F1F0E0E0E0E, encrypting twice returns the original block.
- R11: While reset is asserted and after it is released, `done` is 0 and `blk_out` is all zeros until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request; accepted only when idle |
| mode_dec | input | 1 | 0 = encrypt, 1 = decrypt; sampled with `start` |
| blk_in | input | 64 | Input block; sampled with `start` |
| key_in | input | 64 | Key, parity bits included; sampled with `start` |
| blk_out | output | 64 | Result register |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Any wrong internal state shows up at `blk_out` within the same operation. That includes a misrouted permutation bit, an S-box entry, a rotation step, a subkey taken in the wrong order, or a half register that fails to swap. The cipher's diffusion turns a single bad bit into a heavily changed result on the `done` edge, 16 cycles after `start`.

Control faults show up even sooner, as `done` rising on the wrong edge or lasting two cycles. A round counter that accepts a second start shows up as a corrupted result. Algebraic checks expose errors that one fixed vector might hide: the round trip, the complement symmetry, the self-inverse keys and the parity-bit sweep.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int BLK_W    = 64;
  localparam int HALF_W   = BLK_W / 2;
  localparam int KEY_W    = 64;
  localparam int CD_W     = 56;
  localparam int CDH_W    = CD_W / 2;
  localparam int SUB_W    = 48;
  localparam int N_SBOX   = 8;
  localparam int SB_IN_W  = SUB_W / N_SBOX;
  localparam int SB_OUT_W = HALF_W / N_SBOX;
  localparam int N_ROUNDS = 16;
  localparam int RND_W    = $clog2(N_ROUNDS);

  // Permutation tables use 1-based positions counted from the MSB.
  localparam logic [6:0] PBOX_TAB [HALF_W] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam logic [6:0] KSEL1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam logic [6:0] KSEL2_TAB [SUB_W] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Each box: 64 nibbles, entry 0 in the top nibble, index {row[1:0], col[3:0]}.
  localparam logic [255:0] SBOX_TAB [N_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source position (1-based from MSB) for output position i (0-based) of the entry permutation.
  function automatic int ip_src(input int i);
    int row;
    int col;
    row = i / 8;
    col = i % 8;
    if (row < 4) return 58 + 2 * row - 8 * col;
    else         return 57 + 2 * (row - 4) - 8 * col;
  endfunction

  function automatic logic [BLK_W-1:0] entry_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[6'(63 - i)] = x[6'(64 - ip_src(i))];
    return y;
  endfunction

  // Exact inverse of entry_perm: scatter instead of gather.
  function automatic logic [BLK_W-1:0] exit_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[6'(64 - ip_src(i))] = x[6'(63 - i)];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] expand_half(input logic [HALF_W-1:0] x);
    logic [SUB_W-1:0] y;
    int src;
    y = '0;
    for (int g = 0; g < N_SBOX; g++) begin
      for (int k = 0; k < SB_IN_W; k++) begin
        src = ((4 * g + k + HALF_W - 1) % HALF_W) + 1;
        y[6'(SUB_W - 1 - (g * SB_IN_W + k))] = x[5'(HALF_W - src)];
      end
    end
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] pbox(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    y = '0;
    for (int i = 0; i < HALF_W; i++) y[5'(31 - i)] = x[5'(32 - int'(PBOX_TAB[i]))];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] key_select1(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] y;
    y = '0;
    for (int i = 0; i < CD_W; i++) y[6'(55 - i)] = k[6'(64 - int'(KSEL1_TAB[i]))];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] key_select2(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] y;
    y = '0;
    for (int i = 0; i < SUB_W; i++) y[6'(47 - i)] = cd[6'(56 - int'(KSEL2_TAB[i]))];
    return y;
  endfunction

  function automatic logic [SB_OUT_W-1:0] sbox_lookup(input int box, input logic [SB_IN_W-1:0] b);
    logic [5:0] n;
    n = {b[5], b[0], b[4:1]};
    return SBOX_TAB[3'(box)][8'(255 - 4 * int'(n)) -: 4];
  endfunction

  // Rounds (1-based) whose key halves move by a single position.
  function automatic logic single_step(input int n);
    return (n == 1) || (n == 2) || (n == 9) || (n == 16);
  endfunction

  function automatic logic [CDH_W-1:0] rot_half(input logic [CDH_W-1:0] x, input logic right,
                                                input logic two);
    if (!right) return two ? {x[CDH_W-3:0], x[CDH_W-1:CDH_W-2]} : {x[CDH_W-2:0], x[CDH_W-1]};
    else        return two ? {x[1:0], x[CDH_W-1:2]}             : {x[0], x[CDH_W-1:1]};
  endfunction

endpackage

// File: rtl/des_feistel_f.sv
module des_feistel_f
  import des_pkg::*;
(
  input  logic [HALF_W-1:0] half_in,
  input  logic [SUB_W-1:0]  subkey,
  output logic [HALF_W-1:0] f_out
);

  logic [SUB_W-1:0]  mixed;
  logic [HALF_W-1:0] subst;

  assign mixed = expand_half(half_in) ^ subkey;

  for (genvar g = 0; g < N_SBOX; g++) begin : g_box
    assign subst[HALF_W-1-g*SB_OUT_W -: SB_OUT_W] =
      sbox_lookup(g, mixed[SUB_W-1-g*SB_IN_W -: SB_IN_W]);
  end

  assign f_out = pbox(subst);

endmodule

// File: rtl/des_subkey_gen.sv
module des_subkey_gen
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             mode_dec,
  input  logic [KEY_W-1:0] key_in,
  input  logic [RND_W-1:0] rnd,
  output logic [SUB_W-1:0] subkey
);

  logic [CD_W-1:0] cd_q, cd_d, base;
  logic            dir_q, dir_d;
  logic            two;

  always_comb begin
    cd_d  = cd_q;
    dir_d = dir_q;
    base  = key_select1(key_in);
    two   = 1'b0;
    if (load) begin
      dir_d = mode_dec;
      // Encrypt starts at round 1 (one left step); decrypt starts at round 16 (unrotated).
      cd_d  = mode_dec ? base
                       : {rot_half(base[CD_W-1:CDH_W], 1'b0, 1'b0), rot_half(base[CDH_W-1:0], 1'b0, 1'b0)};
    end else if (step) begin
      two  = !single_step(int'(rnd) + 2);
      cd_d = {rot_half(cd_q[CD_W-1:CDH_W], dir_q, two), rot_half(cd_q[CDH_W-1:0], dir_q, two)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q  <= '0;
      dir_q <= 1'b0;
    end else if (load || step) begin
      cd_q  <= cd_d;
      dir_q <= dir_d;
    end
  end

  assign subkey = key_select2(cd_q);

  // R2: direction stays fixed for the whole operation
  a_r2_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(dir_q));

endmodule

// File: rtl/des_seq_ctrl.sv
module des_seq_ctrl
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [RND_W-1:0] rnd,
  output logic             done
);

  logic             busy_q, busy_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             done_q, done_d;

  always_comb begin
    load   = start && !busy_q;
    step   = busy_q;
    last   = busy_q && (rnd_q == RND_W'(N_ROUNDS - 1));
    busy_d = busy_q;
    rnd_d  = rnd_q;
    if (load) begin
      busy_d = 1'b1;
      rnd_d  = '0;
    end else if (busy_q) begin
      rnd_d = rnd_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  assign rnd  = rnd_q;
  assign done = done_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(load, N_ROUNDS + 1));

  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && rnd_q != RND_W'(N_ROUNDS - 1)) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_dec,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [KEY_W-1:0] key_in,
  output logic [BLK_W-1:0] blk_out,
  output logic             done
);

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              load, step, last;
  logic [RND_W-1:0]  rnd;
  logic [SUB_W-1:0]  subkey;
  logic [HALF_W-1:0] l_q, r_q, l_d, r_d, f_val;
  logic [BLK_W-1:0]  out_q, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  des_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .rnd   (rnd),
    .done  (done)
  );

  des_subkey_gen u_keys (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (load),
    .step     (step),
    .mode_dec (mode_dec),
    .key_in   (key_in),
    .rnd      (rnd),
    .subkey   (subkey)
  );

  des_feistel_f u_f (
    .half_in (r_q),
    .subkey  (subkey),
    .f_out   (f_val)
  );

  always_comb begin
    if (load) begin
      {l_d, r_d} = entry_perm(blk_in);
    end else begin
      l_d = r_q;
      r_d = l_q ^ f_val;
    end
    // Final round output with the halves swapped.
    out_d = exit_perm({l_q ^ f_val, r_q});
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      l_q   <= '0;
      r_q   <= '0;
      out_q <= '0;
    end else begin
      if (load || step) begin
        l_q <= l_d;
        r_q <= r_d;
      end
      if (last) out_q <= out_d;
    end
  end

  assign blk_out = out_q;

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !done |-> $stable(blk_out));

  a_r11_reset_out: assert property (@(posedge clk) !rst_i_n |-> (blk_out == '0 && !done));

endmodule

// File: tb/des_iter_core_tb_top.sv
module des_iter_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode_dec;
  logic [63:0] blk_in;
  logic [63:0] key_in;
  logic [63:0] blk_out;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  des_iter_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_dec (mode_dec),
    .blk_in   (blk_in),
    .key_in   (key_in),
    .blk_out  (blk_out),
    .done     (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %016h expected %016h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  // One operation; leaves the bench on the negedge where done is seen.
  task automatic run_op(input logic dec, input logic [63:0] blk, input logic [63:0] key,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    start = 1'b1; mode_dec = dec; blk_in = blk; key_in = key;
    @(negedge clk);
    start = 1'b0; mode_dec = ~dec; blk_in = ~blk; key_in = ~key;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = blk_out;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: actual run still going, expected completion");
    summary();
  end

  initial begin
    logic [63:0] res, res2, prev, k, p, s;
    int lat;
    start = 0; mode_dec = 0; blk_in = '0; key_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk_int("R11 done in reset", int'(done), 0);
    chk64("R11 out in reset", blk_out, 64'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_int("R11 done after reset", int'(done), 0);
    chk64("R11 out after reset", blk_out, 64'h0);

    // R1 / R2 / R3 / R4 known vectors
    run_op(1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, res, lat);
    chk64("R1 std vector", res, 64'h85E813540F0AB405);
    chk_int("R3 latency", lat, 16);
    @(negedge clk);
    chk_int("R4 done one cycle", int'(done), 0);
    run_op(1'b1, 64'h85E813540F0AB405, 64'h133457799BBCDFF1, res, lat);
    chk64("R2 std vector decrypt", res, 64'h0123456789ABCDEF);
    chk_int("R3 latency decrypt", lat, 16);
    run_op(1'b0, 64'h0, 64'h0, res, lat);
    chk64("R1 zero vector", res, 64'h8CA64DE9C1B123A7);
    run_op(1'b1, 64'h8CA64DE9C1B123A7, 64'h0, res, lat);
    chk64("R2 zero vector decrypt", res, 64'h0);
    run_op(1'b0, '1, '1, res, lat);
    chk64("R1 ones vector", res, 64'h7359B2163E4EDC58);
    run_op(1'b1, 64'h7359B2163E4EDC58, '1, res, lat);
    chk64("R2 ones vector decrypt", res, '1);

    // R6: output holds after done
    prev = blk_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk64("R6 hold", blk_out, prev);
    end

    // R5: start pulses during busy are ignored
    @(negedge clk);
    start = 1; mode_dec = 0; blk_in = 64'h0123456789ABCDEF; key_in = 64'h133457799BBCDFF1;
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 40) begin
      chk64("R6 no change while busy", blk_out, prev);
      start = (lat % 3 == 1); mode_dec = 1; blk_in = ~blk_in; key_in = xs(key_in);
      @(negedge clk);
      lat++;
    end
    start = 0;
    chk_int("R5 latency with extra starts", lat, 16);
    chk64("R5 result with extra starts", blk_out, 64'h85E813540F0AB405);
    @(negedge clk);
    chk_int("R5 R4 no second done", int'(done), 0);
    repeat (20) begin
      @(negedge clk);
      chk_int("R5 no stray done", int'(done), 0);
    end

    // R7: all 256 parity-bit patterns
    for (int m = 0; m < 256; m++) begin
      k = 64'h133457799BBCDFF1;
      for (int b = 0; b < 8; b++) k[8 * b] = k[8 * b] ^ m[b];
      run_op(1'b0, 64'h0123456789ABCDEF, k, res, lat);
      chk64("R7 parity ignored", res, 64'h85E813540F0AB405);
    end

    // R8: round trip, walking-one blocks and pseudo-random keys
    s = 64'h9E3779B97F4A7C15;
    for (int i = 0; i < 64; i++) begin
      s = xs(s);
      p = (64'h1 << i) ^ (i[0] ? s : 64'h0);
      run_op(1'b0, p, s, res, lat);
      run_op(1'b1, res, s, res2, lat);
      chk64("R8 round trip", res2, p);
      chk_int("R3 latency sweep", lat, 16);
    end

    // R9: complement symmetry
    for (int i = 0; i < 32; i++) begin
      s = xs(s); k = s; s = xs(s); p = s;
      run_op(1'b0, p, k, res, lat);
      run_op(1'b0, ~p, ~k, res2, lat);
      chk64("R9 complement", res2, ~res);
    end

    // R10: self-inverse keys
    for (int w = 0; w < 4; w++) begin
      case (w)
        0: k = 64'h0101010101010101;
        1: k = 64'hFEFEFEFEFEFEFEFE;
        2: k = 64'hE0E0E0E0F1F1F1F1;
        default: k = 64'h1F1F1F1F0E0E0E0E;
      endcase
      for (int i = 0; i < 8; i++) begin
        s = xs(s);
        run_op(1'b0, s, k, res, lat);
        run_op(1'b0, res, k, res2, lat);
        chk64("R10 weak key twice", res2, s);
      end
    end

    summary();
  end

endmodule